// File: doc/BRIEF.md
# Matrix Tile Reorder Buffer

This block converts a whole matrix between plain row-major element order and a blocked tile order that suits vector multiply units. It can also perform the inverse conversion. Elements arrive one per handshake on a valid/ready input stream and are written into one of two matrix-sized banks. Once a bank holds a complete matrix, a read-address generator walks it in the selected order and streams the result out on a valid/ready output.

The tiled order walks the rows of one tile, each row from left to right. It then moves to the next tile along the same band of tile rows, and only after the last tile column does it drop to the next band. When a matrix is flagged as column-major on input, it is transposed on the way through, so the output follows the tiled order of the logical matrix. In untile mode, the input is taken to be in tiled order and the output is plain row-major.

The two banks work in ping-pong fashion: one matrix can be captured while the previous one drains. The mode inputs are sampled with the first element of each matrix and stay attached to that bank.

Top module: `mtr_tile_reorder`

## Requirements
- R1: After reset, out_valid_o is 0 and in_ready_o is 1.
- R2: In tile mode with row-major input, output position p carries the element at row r = tr*TILE_R + i and column c = tc*TILE_C + j. The fields are j = p mod TILE_C, i = (p / TILE_C) mod TILE_R, tc = (p / (TILE_C*TILE_R)) mod (COLS/TILE_C) and tr = p / (TILE_C*TILE_R*COLS/TILE_C). Row-major arrival index k = r*COLS + c. Within each tile, rows come out top to bottom and each row left to right.
- R3: In tile mode, every tile of a band of TILE_R rows is emitted, left to right across the tile columns, before any element of the next band.
- R4: In tile mode with col_major_i = 1, input arrival index k = c*ROWS + r, and the output follows the same tiled walk over (r, c) as R2, which transposes the data.
- R5: In untile mode (untile_i = 1), the input is in tiled order. Output position p = r*COLS + c carries arrival index ((r/TILE_R * COLS/TILE_C + c/TILE_C)*TILE_R + r mod TILE_R)*TILE_C + c mod TILE_C.
- R6: In untile mode, col_major_i has no effect on the output order.
- R7: untile_i and col_major_i are sampled only with the first element of a matrix. Changes during the rest of its capture do not alter how that matrix is read out.
- R8: out_valid_o stays 0 until the last element of a matrix has been accepted. It is 1 from the next cycle until that matrix has fully drained, and it is 0 whenever no complete matrix is held.
- R9: A second matrix can be accepted while the first is being read. in_ready_o is 0 exactly while two complete matrices are held unread.
- R10: While out_valid_o = 1 and out_ready_i = 0, out_valid_o and out_data_o hold their values into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| untile_i | input | 1 | 1: tiled in, row-major out; 0: tile the matrix |
| col_major_i | input | 1 | Input matrix is column-major (tile mode only) |
| in_data_i | input | DW | Input element |
| in_valid_i | input | 1 | Input element valid |
| in_ready_o | output | 1 | Block can accept an element |
| out_data_o | output | DW | Output element |
| out_valid_o | output | 1 | Output element valid |
| out_ready_i | input | 1 | Downstream accepts the element |

## Verification
The hardest state to reach from the ports has both banks full: one waiting and one part-drained, while the writer is stalled and the mode inputs keep changing under a capture. The stimulus gets there by holding out_ready_i low until the bench's own count of complete matrices reaches two. It then releases the output while the input keeps pushing a third matrix, whose mode lines flip after its first element. Gapped input and gapped output patterns interleave bank switches with stalls, so a bank swap lands both on a cycle that has a handshake and on one that does not.

// File: rtl/mtr_pkg.sv
package mtr_pkg;
  typedef struct packed {
    logic untile;
    logic col_major;
  } mtr_mode_t;

  function automatic int cw(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/mtr_addr_gen.sv
module mtr_addr_gen
  import mtr_pkg::*;
#(
  parameter int ROWS   = 8,
  parameter int COLS   = 8,
  parameter int TILE_R = 4,
  parameter int TILE_C = 2,
  parameter int AW     = cw(ROWS * COLS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          step_i,
  input  mtr_mode_t     mode_i,
  output logic [AW-1:0] addr_o,
  output logic          last_o
);
  localparam int TRN = ROWS / TILE_R;
  localparam int TCN = COLS / TILE_C;
  localparam int JW  = cw(TILE_C);
  localparam int IW  = cw(TILE_R);
  localparam int CW  = cw(TCN);
  localparam int RW  = cw(TRN);

  logic [JW-1:0] cj_q;
  logic [IW-1:0] ci_q;
  logic [CW-1:0] ctc_q;
  logic [RW-1:0] ctr_q;
  logic j_end, i_end, tc_end, tr_end;
  logic inc_i, inc_tc, inc_tr;

  assign j_end  = cj_q  == JW'(TILE_C - 1);
  assign i_end  = ci_q  == IW'(TILE_R - 1);
  assign tc_end = ctc_q == CW'(TCN - 1);
  assign tr_end = ctr_q == RW'(TRN - 1);
  assign last_o = j_end & i_end & tc_end & tr_end;

  // tile walk: j, i, tc, tr ; row-major walk: j, tc, i, tr
  always_comb begin
    if (mode_i.untile) begin
      inc_tc = j_end;
      inc_i  = j_end & tc_end;
    end else begin
      inc_i  = j_end;
      inc_tc = j_end & i_end;
    end
    inc_tr = j_end & i_end & tc_end;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cj_q  <= '0;
      ci_q  <= '0;
      ctc_q <= '0;
      ctr_q <= '0;
    end else if (step_i) begin
      cj_q <= j_end ? '0 : cj_q + JW'(1);
      if (inc_i)  ci_q  <= i_end  ? '0 : ci_q  + IW'(1);
      if (inc_tc) ctc_q <= tc_end ? '0 : ctc_q + CW'(1);
      if (inc_tr) ctr_q <= tr_end ? '0 : ctr_q + RW'(1);
    end
  end

  always_comb begin
    int r, c, t;
    r = int'(ctr_q) * TILE_R + int'(ci_q);
    c = int'(ctc_q) * TILE_C + int'(cj_q);
    t = ((int'(ctr_q) * TCN + int'(ctc_q)) * TILE_R + int'(ci_q)) * TILE_C + int'(cj_q);
    if (mode_i.untile)         addr_o = AW'(t);
    else if (mode_i.col_major) addr_o = AW'(c * ROWS + r);
    else                       addr_o = AW'(r * COLS + c);
  end
endmodule

// File: rtl/mtr_pp_mem.sv
module mtr_pp_mem #(
  parameter int DW    = 16,
  parameter int DEPTH = 64,
  parameter int AW    = 6
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic          wbank_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          rbank_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] rd [2];

  for (genvar b = 0; b < 2; b++) begin : g_bank
    logic [DW-1:0] mem [DEPTH];
    always_ff @(posedge clk_i) begin
      if (we_i && wbank_i == 1'(b)) mem[waddr_i] <= wdata_i;
    end
    assign rd[b] = mem[raddr_i];
  end

  assign rdata_o = rd[rbank_i];
endmodule

// File: rtl/mtr_tile_reorder.sv
module mtr_tile_reorder
  import mtr_pkg::*;
#(
  parameter int ROWS   = 8,
  parameter int COLS   = 8,
  parameter int TILE_R = 4,
  parameter int TILE_C = 2,
  parameter int DW     = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          untile_i,
  input  logic          col_major_i,
  input  logic [DW-1:0] in_data_i,
  input  logic          in_valid_i,
  output logic          in_ready_o,
  output logic [DW-1:0] out_data_o,
  output logic          out_valid_o,
  input  logic          out_ready_i
);
  localparam int N  = ROWS * COLS;
  localparam int AW = cw(N);

  if ((ROWS % TILE_R) != 0 || (COLS % TILE_C) != 0) begin : g_bad_dims
    $error("matrix dimensions must be multiples of the tile dimensions");
  end

  logic [1:0]    full_q;
  logic          wr_sel_q, rd_sel_q;
  logic [AW-1:0] wcnt_q;
  mtr_mode_t     bank_mode_q [2];
  logic          wr_fire, wr_last, rd_fire, rd_last;
  logic [AW-1:0] raddr;

  assign in_ready_o  = ~full_q[wr_sel_q];
  assign out_valid_o = full_q[rd_sel_q];
  assign wr_fire     = in_valid_i & in_ready_o;
  assign rd_fire     = out_valid_o & out_ready_i;
  assign wr_last     = wcnt_q == AW'(N - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_q         <= '0;
      wr_sel_q       <= 1'b0;
      rd_sel_q       <= 1'b0;
      wcnt_q         <= '0;
      bank_mode_q[0] <= '0;
      bank_mode_q[1] <= '0;
    end else begin
      if (wr_fire) begin
        wcnt_q <= wr_last ? '0 : wcnt_q + AW'(1);
        // mode belongs to the matrix: taken with its first element
        if (wcnt_q == '0) bank_mode_q[wr_sel_q] <= '{untile: untile_i, col_major: col_major_i};
        if (wr_last) begin
          full_q[wr_sel_q] <= 1'b1;
          wr_sel_q         <= ~wr_sel_q;
        end
      end
      if (rd_fire && rd_last) begin
        full_q[rd_sel_q] <= 1'b0;
        rd_sel_q         <= ~rd_sel_q;
      end
    end
  end

  mtr_addr_gen #(
    .ROWS(ROWS), .COLS(COLS), .TILE_R(TILE_R), .TILE_C(TILE_C), .AW(AW)
  ) u_addr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .step_i (rd_fire),
    .mode_i (bank_mode_q[rd_sel_q]),
    .addr_o (raddr),
    .last_o (rd_last)
  );

  mtr_pp_mem #(.DW(DW), .DEPTH(N), .AW(AW)) u_mem (
    .clk_i   (clk_i),
    .we_i    (wr_fire),
    .wbank_i (wr_sel_q),
    .waddr_i (wcnt_q),
    .wdata_i (in_data_i),
    .rbank_i (rd_sel_q),
    .raddr_i (raddr),
    .rdata_o (out_data_o)
  );
endmodule

// File: rtl/mtr_tile_chk.sv
module mtr_tile_chk #(
  parameter int N  = 64,
  parameter int DW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          in_valid_i,
  input logic          in_ready_o,
  input logic          out_valid_o,
  input logic          out_ready_i,
  input logic [DW-1:0] out_data_o
);
  int         in_cnt, out_cnt;
  logic [1:0] occ;
  logic       in_done, out_done;

  assign in_done  = in_valid_i && in_ready_o && in_cnt == N - 1;
  assign out_done = out_valid_o && out_ready_i && out_cnt == N - 1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_cnt  <= 0;
      out_cnt <= 0;
      occ     <= '0;
    end else begin
      if (in_valid_i && in_ready_o)   in_cnt  <= in_done  ? 0 : in_cnt + 1;
      if (out_valid_o && out_ready_i) out_cnt <= out_done ? 0 : out_cnt + 1;
      occ <= occ + 2'(in_done) - 2'(out_done);
    end
  end

  p_empty_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    occ == 2'd0 |-> !out_valid_o);
  p_held_shown_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    occ != 2'd0 |-> out_valid_o);
  p_stall_full_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    occ == 2'd2 |-> !in_ready_o);
  p_accept_free_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    occ < 2'd2 |-> in_ready_o);
  p_occ_bound_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    occ != 2'd3);
  p_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_data_o));
endmodule

bind mtr_tile_reorder mtr_tile_chk #(.N(ROWS * COLS), .DW(DW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .in_valid_i  (in_valid_i),
  .in_ready_o  (in_ready_o),
  .out_valid_o (out_valid_o),
  .out_ready_i (out_ready_i),
  .out_data_o  (out_data_o)
);

// File: tb/tb_mtr_tile_reorder.sv
`timescale 1ns/1ps
module tb_mtr_tile_reorder;
  localparam int ROWS = 8, COLS = 8, TR = 4, TC = 2, DW = 16;
  localparam int N = ROWS * COLS, TCN = COLS / TC;

  logic clk = 0, rst_n = 0;
  logic untile = 0, colmaj = 0, in_valid = 0, out_ready = 0;
  logic [DW-1:0] in_data = '0;
  logic in_ready, out_valid;
  logic [DW-1:0] out_data;

  always #10 clk = ~clk;

  mtr_tile_reorder #(.ROWS(ROWS), .COLS(COLS), .TILE_R(TR), .TILE_C(TC), .DW(DW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .untile_i(untile), .col_major_i(colmaj),
    .in_data_i(in_data), .in_valid_i(in_valid), .in_ready_o(in_ready),
    .out_data_o(out_data), .out_valid_o(out_valid), .out_ready_i(out_ready));

  int checks = 0, errors = 0;
  bit done = 0;
  bit mu[4], mc[4];
  string tg[4];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int exp_k(input int p, input bit un, input bit cm);
    int r, c;
    if (un) begin
      r = p / COLS; c = p % COLS;
      return ((r / TR * TCN + c / TC) * TR + r % TR) * TC + c % TC;
    end
    c = (p / (TC * TR)) % TCN * TC + p % TC;
    r = p / (TC * TR * TCN) * TR + (p / TC) % TR;
    return cm ? c * ROWS + r : r * COLS + c;
  endfunction

  function automatic string pick_tag(input int m, input int p);
    if (tg[m] != "") return tg[m];
    if (mu[m]) return "R5";
    if (mc[m]) return "R4";
    if (p % (TR * TC) == 0) return "R3";
    return "R2";
  endfunction

  task automatic run(input int nm, input int in_pat, input int out_pat, input bit scramble);
    int sm = 0, sk = 0, rm = 0, rk = 0, occ = 0, cyc = 0;
    bit prev_stall = 0;
    logic [DW-1:0] prev_data = '0;
    while (rm < nm) begin
      bit hs_in, hs_out;
      @(negedge clk);
      in_valid = (sm < nm) && (in_pat == 0 || (in_pat == 1 && cyc % 2 == 0) ||
                               (in_pat == 2 && cyc % 3 != 0));
      if (sm < nm) begin
        in_data = DW'((sm << 8) | sk);
        untile  = (scramble && sk != 0) ? !mu[sm] : mu[sm];
        colmaj  = (scramble && sk != 0) ? !mc[sm] : mc[sm];
      end
      out_ready = (out_pat == 0) || (out_pat == 1 && cyc % 2 == 1) ||
                  (out_pat == 2 && (occ == 2 || sm == nm));
      chk(out_valid == (occ > 0), "R8 out_valid", int'(out_valid), int'(occ > 0));
      chk(in_ready == (occ < 2), "R9 in_ready", int'(in_ready), int'(occ < 2));
      if (prev_stall)
        chk(out_valid && out_data == prev_data, "R10 hold", int'(out_data), int'(prev_data));
      prev_stall = out_valid && !out_ready;
      prev_data  = out_data;
      hs_in  = in_valid && in_ready;
      hs_out = out_valid && out_ready;
      if (hs_out) begin
        int e;
        e = (rm << 8) | exp_k(rk, mu[rm], mc[rm]);
        chk(int'(out_data) == e, pick_tag(rm, rk), int'(out_data), e);
      end
      if (hs_in) begin
        sk++;
        if (sk == N) begin sk = 0; sm++; occ++; end
      end
      if (hs_out) begin
        rk++;
        if (rk == N) begin rk = 0; rm++; occ--; end
      end
      cyc++;
    end
    @(negedge clk);
    in_valid = 0; out_ready = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(out_valid == 0, "R1 out_valid", int'(out_valid), 0);
    chk(in_ready == 1, "R1 in_ready", int'(in_ready), 1);

    // R2 R3: plain tiling, full throughput
    mu = '{0, 0, 0, 0}; mc = '{0, 0, 0, 0}; tg = '{"", "", "", ""};
    run(2, 0, 0, 0);
    // R4 transpose, gapped input, gapped output (R10 stalls)
    mu = '{0, 0, 0, 0}; mc = '{1, 1, 0, 0};
    run(2, 1, 1, 0);
    // R5 untile, R6 untile with col_major set, mixed per-bank modes
    mu = '{1, 1, 0, 0}; mc = '{0, 1, 1, 0}; tg = '{"R5", "R6", "", ""};
    run(3, 2, 1, 0);
    // R7 mode lines flip after first element; R9 both banks full
    mu = '{0, 1, 0, 0}; mc = '{0, 0, 1, 0}; tg = '{"R7", "R7", "R7", ""};
    run(3, 0, 2, 1);
    // R8 output waits for the last element
    mu = '{0, 0, 0, 0}; mc = '{0, 0, 0, 0}; tg = '{"", "", "", ""};
    untile = 0; colmaj = 0;
    for (int k = 0; k < N; k++) begin
      in_valid = 1; in_data = DW'(k);
      @(negedge clk);
      if (k < N - 1) chk(out_valid == 0, "R8 early", int'(out_valid), 0);
    end
    in_valid = 0;
    chk(out_valid == 1, "R8 ready after last", int'(out_valid), 1);
    chk(int'(out_data) == exp_k(0, 0, 0), "R2 first", int'(out_data), exp_k(0, 0, 0));
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule